// File: doc/BRIEF.md
# T1 Transmit Elastic Store

This block is a slip buffer on the transmit side of a T1 line interface. It takes serial frames from a system backplane and hands them to the 1.544 MHz line side. Each side runs on its own bit strobe, and both strobes are qualified by one shared core clock. The backplane runs either at the T1 rate (193 bits per frame) or at 2.048 MHz (32 eight-bit timeslots per frame). In the 2.048 MHz case, every fourth timeslot is dropped. The remaining 24 slots fill the 24 T1 channels in order. The F-bit comes from the first bit of slot 0, and a channel-block output marks the dropped slots.

In normal operation the buffer holds two whole T1 frames (386 bits). The line side takes one frame per line frame period, and the F-bit leaves first. If no new frame is ready, the last frame is sent again. If two frames are waiting, the older one is dropped. Either event is a controlled slip, and it sets a sticky flag plus a direction code. A low-latency mode instead runs a 32-bit ring with a fixed 16-bit delay and no slip handling. A rising edge on the re-centre input restores the nominal pointer spacing.

Top module: `tx_elastic_store`

## Requirements
- R1: After reset, `tx_o`, `chblk_o`, `slip_o` and `slip_dir_o` are all 0.
- R2: With `store_en_i`=1, `rate_2m_i`=0, and frames of 193 backplane bits arriving at the line rate (`fsync_i` high with bit 0), line frame k+1 carries backplane frame k bit for bit. Bit 0 is the F-bit and leaves first. `tx_o` updates on the clock edge that samples `line_en_i`.
- R3: With `rate_2m_i`=1, a frame is 256 backplane bits (slot = bit index / 8, bit in slot = bit index mod 8). Slots 0, 4, 8, …, 28 are discarded, except bit 0 of slot 0, which becomes the F-bit. Slot s with s mod 4 ≠ 0 becomes channel c = 3·(s/4) + (s mod 4) − 1. Its bit b is T1 frame bit 1 + 8c + b.
- R4: After each backplane strobe, `chblk_o` is 1 exactly when `rate_2m_i`=1 and the strobed bit lies in a slot that is a multiple of 4. In 1.544 mode it stays 0.
- R5: `fsync_i` sampled with `sys_en_i` makes that bit bit 0 of a backplane frame, whatever came before it.
- R6: When a line frame starts and no complete unread frame is held, the previous frame is repeated. `slip_o` is then set and `slip_dir_o` = 01.
- R7: When a line frame starts and two complete unread frames are held, the older one is dropped and the newer one is sent. `slip_o` is then set and `slip_dir_o` = 10.
- R8: `slip_o` and `slip_dir_o` hold their value until `stat_clr_i` is pulsed, which returns both to 0.
- R9: With `min_dly_i`=1 and both strobes in step, `tx_o` after strobe n equals the `ser_i` bit of strobe n−16, and `slip_o` never sets.
- R10: A 0-to-1 transition of `es_rst_i` restores the nominal spacing. In low-latency mode this is the 16-bit delay; in normal mode it is one frame pending.
- R11: With `store_en_i`=0, `tx_o` takes `ser_i` on every line strobe and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock qualifying both strobes |
| rst_ni | input | 1 | Active-low asynchronous reset |
| store_en_i | input | 1 | 1 = buffer in path, 0 = bypass |
| rate_2m_i | input | 1 | Backplane format: 0 = 193-bit, 1 = 256-bit |
| min_dly_i | input | 1 | Low-latency 32-bit ring mode |
| es_rst_i | input | 1 | Re-centre request, acts on rising edge |
| stat_clr_i | input | 1 | Clears slip status |
| sys_en_i | input | 1 | Backplane bit strobe |
| ser_i | input | 1 | Backplane serial data |
| fsync_i | input | 1 | Backplane frame start, valid with sys_en_i |
| chblk_o | output | 1 | High during discarded backplane slots |
| line_en_i | input | 1 | Line-side bit strobe |
| tx_o | output | 1 | Line-side serial data |
| slip_o | output | 1 | Sticky controlled-slip flag |
| slip_dir_o | output | 2 | 01 repeated frame, 10 deleted frame |

## Verification
The assertions assume a few things about the inputs. Each strobe lasts exactly one core clock. Mode inputs change only while reset is held. `es_rst_i` rises in a cycle with no strobes. A frame slip is only ever requested at a line frame boundary. The stimulus meets these conditions as follows. It changes configuration only across a reset. It pauses either strobe only for whole frames, lined up on frame boundaries. It pulses the re-centre and clear inputs in idle cycles. This keeps every slip a clean whole-frame event whose direction and data can be predicted.

// File: rtl/tes_pkg.sv
package tes_pkg;
  localparam int T1_BITS   = 193;
  localparam int BP_BITS   = 256;
  localparam int SLOT_BITS = 8;
  localparam int PW        = $clog2(BP_BITS);
  localparam int SW        = $clog2(SLOT_BITS);

  typedef enum logic [1:0] {
    SLIP_NONE   = 2'b00,
    SLIP_REPEAT = 2'b01,
    SLIP_DELETE = 2'b10
  } slip_dir_e;
endpackage

// File: rtl/tes_wr_map.sv
module tes_wr_map
  import tes_pkg::*;
#(
  parameter int FRAME_BITS = T1_BITS,
  parameter int BW         = $clog2(FRAME_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sys_en_i,
  input  logic          fsync_i,
  input  logic          rate_2m_i,
  output logic          wr_en_o,
  output logic [BW-1:0] wr_bit_o,
  output logic          wr_done_o,
  output logic          chblk_o
);
  logic [PW-1:0]    pos_q, cur, last;
  logic [PW-SW-1:0] ts;
  logic [SW-1:0]    bb;
  logic [4:0]       ch;
  logic             chblk_q;

  always_comb begin
    last     = rate_2m_i ? PW'(BP_BITS - 1) : PW'(FRAME_BITS - 1);
    cur      = (fsync_i || pos_q >= last) ? '0 : pos_q + 1'b1;
    ts       = cur[PW-1:SW];
    bb       = cur[SW-1:0];
    ch       = 5'(ts[4:2]) * 5'd3 + 5'(ts[1:0]) - 5'd1;
    wr_en_o  = sys_en_i;
    wr_bit_o = BW'(cur);
    if (rate_2m_i) begin
      if (ts[1:0] == 2'b00) begin
        // only the first bit of slot 0 survives (F-bit)
        wr_en_o  = sys_en_i && (cur == '0);
        wr_bit_o = '0;
      end else begin
        wr_bit_o = BW'({ch, bb}) + 1'b1;
      end
    end
    wr_done_o = wr_en_o && (wr_bit_o == BW'(FRAME_BITS - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '1;
      chblk_q <= 1'b0;
    end else if (sys_en_i) begin
      pos_q   <= cur;
      chblk_q <= rate_2m_i && (ts[1:0] == 2'b00);
    end
  end

  assign chblk_o = chblk_q;

  // R3
  wr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_bit_o < BW'(FRAME_BITS)));
endmodule

// File: rtl/tes_slip_ctl.sv
module tes_slip_ctl
  import tes_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       min_i,
  input  logic       rd_start_i,
  input  logic       wr_done_i,
  input  logic       es_rise_i,
  input  logic       stat_clr_i,
  output logic       ws_o,
  output logic       rs_sel_o,
  output logic       slip_o,
  output logic [1:0] slip_dir_o
);
  logic [1:0] pend_q;
  logic [2:0] pend_eff;
  logic       ws_q, rs_q, pick, slip_ev, slip_q;
  slip_dir_e  dir_ev, dir_q;

  always_comb begin
    pick     = rd_start_i && !min_i;
    pend_eff = {1'b0, pend_q} + 3'(wr_done_i);
    rs_sel_o = rs_q;
    slip_ev  = 1'b0;
    dir_ev   = SLIP_NONE;
    if (pick) begin
      if (pend_eff == 3'd0) begin
        slip_ev = 1'b1;
        dir_ev  = SLIP_REPEAT;
      end else begin
        // newest complete slot: the one finishing now, else the idle one
        rs_sel_o = wr_done_i ? ws_q : ~ws_q;
        if (pend_eff >= 3'd2) begin
          slip_ev = 1'b1;
          dir_ev  = SLIP_DELETE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 2'd1;
      ws_q   <= 1'b0;
      rs_q   <= 1'b1;
      slip_q <= 1'b0;
      dir_q  <= SLIP_NONE;
    end else begin
      rs_q <= rs_sel_o;
      if (wr_done_i) ws_q <= ~ws_q;
      if (es_rise_i)                        pend_q <= 2'd1;
      else if (pick)                        pend_q <= 2'd0;
      else if (wr_done_i && pend_q != 2'd3) pend_q <= pend_q + 2'd1;
      if (slip_ev) begin
        slip_q <= 1'b1;
        dir_q  <= dir_ev;
      end else if (stat_clr_i) begin
        slip_q <= 1'b0;
        dir_q  <= SLIP_NONE;
      end
    end
  end

  assign ws_o       = ws_q;
  assign slip_o     = slip_q;
  assign slip_dir_o = dir_q;

  // R7
  dir_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slip_dir_o));
  // R6
  slip_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slip_o) |-> $past(rd_start_i));
  // R9
  no_slip_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slip_o) |-> !$past(min_i));
endmodule

// File: rtl/tes_frame_buf.sv
module tes_frame_buf
  import tes_pkg::*;
#(
  parameter int FRAME_BITS = T1_BITS,
  parameter int MIN_DEPTH  = 32,
  parameter int BW         = $clog2(FRAME_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          min_i,
  input  logic          wr_en_i,
  input  logic [BW-1:0] wr_bit_i,
  input  logic          wr_data_i,
  input  logic          ws_i,
  input  logic          line_en_i,
  input  logic          rs_sel_i,
  input  logic          es_rise_i,
  input  logic          ser_i,
  output logic          rd_start_o,
  output logic          tx_o
);
  localparam int DEPTH = 2 * FRAME_BITS;
  localparam int AW    = $clog2(DEPTH);
  localparam int MW    = $clog2(MIN_DEPTH);
  localparam int HALF  = MIN_DEPTH / 2;

  logic [DEPTH-1:0] mem_q;
  logic [AW-1:0]    waddr, raddr;
  logic [BW-1:0]    rbit_q;
  logic [MW-1:0]    wp_q, rp_q;
  logic             tx_q, wr_go;

  always_comb begin
    wr_go      = en_i && wr_en_i;
    waddr      = min_i ? AW'(wp_q)
                       : (ws_i ? AW'(FRAME_BITS) : '0) + AW'(wr_bit_i);
    raddr      = min_i ? AW'(rp_q)
                       : (rs_sel_i ? AW'(FRAME_BITS) : '0) + AW'(rbit_q);
    rd_start_o = line_en_i && en_i && (rbit_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '0;
      rbit_q <= '0;
      wp_q   <= MW'(HALF);
      rp_q   <= '0;
      tx_q   <= 1'b0;
    end else begin
      if (wr_go) mem_q[waddr] <= wr_data_i;
      if (wr_go && min_i) wp_q <= wp_q + 1'b1;
      if (es_rise_i)                 rp_q <= wp_q - MW'(HALF);
      else if (line_en_i && min_i)   rp_q <= rp_q + 1'b1;
      if (line_en_i) begin
        rbit_q <= (rbit_q == BW'(FRAME_BITS - 1)) ? '0 : rbit_q + 1'b1;
        tx_q   <= en_i ? mem_q[raddr] : ser_i;
      end
    end
  end

  assign tx_o = tx_q;

  // R2
  rbit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbit_q < BW'(FRAME_BITS));
endmodule

// File: rtl/tx_elastic_store.sv
module tx_elastic_store
  import tes_pkg::*;
#(
  parameter int FRAME_BITS = T1_BITS,
  parameter int MIN_DEPTH  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       store_en_i,
  input  logic       rate_2m_i,
  input  logic       min_dly_i,
  input  logic       es_rst_i,
  input  logic       stat_clr_i,
  input  logic       sys_en_i,
  input  logic       ser_i,
  input  logic       fsync_i,
  output logic       chblk_o,
  input  logic       line_en_i,
  output logic       tx_o,
  output logic       slip_o,
  output logic [1:0] slip_dir_o
);
  localparam int BW = $clog2(FRAME_BITS);

  logic          es_q, es_rise;
  logic          wr_en, wr_done, ws, rs_sel, rd_start;
  logic [BW-1:0] wr_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) es_q <= 1'b0;
    else         es_q <= es_rst_i;
  end
  assign es_rise = es_rst_i && !es_q;

  tes_wr_map #(.FRAME_BITS(FRAME_BITS), .BW(BW)) u_wr_map (
    .clk_i, .rst_ni,
    .sys_en_i, .fsync_i, .rate_2m_i,
    .wr_en_o  (wr_en),
    .wr_bit_o (wr_bit),
    .wr_done_o(wr_done),
    .chblk_o
  );

  tes_slip_ctl u_slip_ctl (
    .clk_i, .rst_ni,
    .min_i     (min_dly_i),
    .rd_start_i(rd_start),
    .wr_done_i (wr_done && store_en_i),
    .es_rise_i (es_rise),
    .stat_clr_i,
    .ws_o      (ws),
    .rs_sel_o  (rs_sel),
    .slip_o,
    .slip_dir_o
  );

  tes_frame_buf #(.FRAME_BITS(FRAME_BITS), .MIN_DEPTH(MIN_DEPTH), .BW(BW)) u_frame_buf (
    .clk_i, .rst_ni,
    .en_i      (store_en_i),
    .min_i     (min_dly_i),
    .wr_en_i   (wr_en),
    .wr_bit_i  (wr_bit),
    .wr_data_i (ser_i),
    .ws_i      (ws),
    .line_en_i,
    .rs_sel_i  (rs_sel),
    .es_rise_i (es_rise),
    .ser_i,
    .rd_start_o(rd_start),
    .tx_o
  );
endmodule

// File: tb/tx_elastic_store_tb.sv
module tx_elastic_store_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic store_en = 1'b0, rate_2m = 1'b0, min_dly = 1'b0, es_rst = 1'b0, stat_clr = 1'b0;
  logic sys_en = 1'b0, ser = 1'b0, fsync = 1'b0, line_en = 1'b0;
  logic chblk, tx, slip;
  logic [1:0] slip_dir;
  int n_chk = 0, n_bad = 0;
  logic hist [0:599];

  always #2 clk = ~clk;

  tx_elastic_store u_dut (
    .clk_i(clk), .rst_ni(rst_n), .store_en_i(store_en), .rate_2m_i(rate_2m),
    .min_dly_i(min_dly), .es_rst_i(es_rst), .stat_clr_i(stat_clr),
    .sys_en_i(sys_en), .ser_i(ser), .fsync_i(fsync), .chblk_o(chblk),
    .line_en_i(line_en), .tx_o(tx), .slip_o(slip), .slip_dir_o(slip_dir)
  );

  function automatic logic gen(input int f, input int b);
    logic [31:0] h;
    h = 32'(f) * 32'h9E3779B1 + 32'(b) * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return h[20];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic l, input logic d, input logic f);
    sys_en = s; line_en = l; ser = d; fsync = f;
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic en, input logic r2m, input logic mn);
    rst_n = 1'b0; sys_en = 0; line_en = 0; ser = 0; fsync = 0;
    store_en = en; rate_2m = r2m; min_dly = mn; es_rst = 0; stat_clr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_up();
  end

  initial begin
    // R1 reset state
    do_reset(1'b1, 1'b0, 1'b0);
    chk("R1 tx", 8'(tx), 0);
    chk("R1 chblk", 8'(chblk), 0);
    chk("R1 slip", 8'(slip), 0);
    chk("R1 dir", 8'(slip_dir), 0);

    // R2 locked 1.544 operation: line frame f carries frame f-1
    for (int f = 0; f < 6; f++)
      for (int b = 0; b < 193; b++) begin
        step(1, 1, gen(f, b), b == 0);
        if (f >= 1) chk("R2 data", 8'(tx), 8'(gen(f - 1, b)));
        if (b == 50) chk("R4 chblk 1.544", 8'(chblk), 0);
      end
    chk("R2 no slip", 8'(slip), 0);

    // R6 writer misses one frame -> repeat
    for (int b = 0; b < 193; b++) begin
      step(0, 1, 1'b0, 1'b0);
      chk("R2 data", 8'(tx), 8'(gen(5, b)));
    end
    for (int b = 0; b < 193; b++) begin
      step(1, 1, gen(6, b), b == 0);
      chk("R6 repeat data", 8'(tx), 8'(gen(5, b)));
      if (b == 0) begin
        chk("R6 slip", 8'(slip), 1);
        chk("R6 dir", 8'(slip_dir), 8'h01);
      end
    end
    for (int b = 0; b < 193; b++) begin
      step(1, 1, gen(7, b), b == 0);
      chk("R6 after repeat", 8'(tx), 8'(gen(6, b)));
    end
    chk("R8 slip held", 8'(slip), 1);
    chk("R8 dir held", 8'(slip_dir), 8'h01);

    // R8 clear
    stat_clr = 1'b1;
    step(0, 0, 1'b0, 1'b0);
    stat_clr = 1'b0;
    chk("R8 slip cleared", 8'(slip), 0);
    chk("R8 dir cleared", 8'(slip_dir), 0);

    // R7 line misses one frame -> delete
    for (int b = 0; b < 193; b++) step(1, 0, gen(8, b), b == 0);
    for (int b = 0; b < 193; b++) begin
      step(1, 1, gen(9, b), b == 0);
      chk("R7 delete data", 8'(tx), 8'(gen(8, b)));
      if (b == 0) begin
        chk("R7 slip", 8'(slip), 1);
        chk("R7 dir", 8'(slip_dir), 8'h02);
      end
    end
    for (int b = 0; b < 193; b++) begin
      step(1, 1, gen(10, b), b == 0);
      chk("R7 after delete", 8'(tx), 8'(gen(9, b)));
    end

    // R3 R4 R5: 2.048 backplane, preceded by unsynced junk
    do_reset(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 100; i++) begin
      step(1, 0, 1'b1, 1'b0);
      chk("R4 chblk junk", 8'(chblk), 8'(((i / 8) % 4) == 0));
    end
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 256; c++) begin
        int ts, bb;
        logic d;
        ts = c / 8; bb = c % 8;
        if (ts % 4 == 0) d = (c == 0) ? gen(k, 0) : 1'b1;
        else d = gen(k, 1 + (3 * (ts / 4) + ts % 4 - 1) * 8 + bb);
        step(1, c < 193, d, c == 0);
        chk("R4 chblk", 8'(chblk), 8'(ts % 4 == 0));
        if (c < 193 && k >= 1) chk("R3 R5 mapped data", 8'(tx), 8'(gen(k - 1, c)));
      end
    chk("R3 no slip", 8'(slip), 0);

    // R9 R10 low-latency ring
    do_reset(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 400; i++) begin
      hist[i] = gen(50, i);
      step(1, 1, hist[i], (i % 193) == 0);
      if (i >= 16) chk("R9 delay 16", 8'(tx), 8'(hist[i - 16]));
    end
    for (int i = 400; i < 405; i++) begin
      hist[i] = gen(50, i);
      step(1, 0, hist[i], 1'b0);
    end
    chk("R9 no slip", 8'(slip), 0);
    es_rst = 1'b1;
    step(0, 0, 1'b0, 1'b0);
    es_rst = 1'b0;
    for (int i = 405; i < 500; i++) begin
      hist[i] = gen(50, i);
      step(1, 1, hist[i], 1'b0);
      chk("R10 recentred", 8'(tx), 8'(hist[i - 16]));
    end
    chk("R9 no slip end", 8'(slip), 0);

    // R11 bypass
    do_reset(1'b0, 1'b0, 1'b0);
    begin
      logic exp_tx;
      exp_tx = 1'b0;
      for (int i = 0; i < 24; i++) begin
        logic d, l;
        d = gen(77, i);
        l = (i % 3) != 2;
        step(1, l, d, i == 0);
        if (l) exp_tx = d;
        chk("R11 bypass", 8'(tx), 8'(exp_tx));
      end
    end

    finish_up();
  end
endmodule